// File: doc/BRIEF.md
# Register-Mapped SPI Byte Master

This block is an SPI master driven through six 32-bit word registers. Software picks one of eight active-low select lines, chooses a clock polarity and phase, and sets a two-field clock prescaler. It then writes a byte to the transmit register. That write starts one full-duplex exchange of eight bits, most significant bit first, while a byte from MISO is shifted in.

Software drives the select line itself and can hold it low across any number of bytes. Completion is reported in two ways: a ready flag that software can poll, and a sticky event bit whose masked value drives an interrupt line. The register bus has no wait states. Writes take effect on the clock edge, and read data is a combinational function of the address.

Top module: `spi_byte_master`

## Requirements
- R1: After reset all eight select lines are high, `irq_o` is low, `sck_o` is low, and the control register reads 0.
- R2: Control register (offset 0x0) bit 0 enables selection and bits 4:2 hold a select index. While bit 0 is 1, only the line whose number equals the index is low. While bit 0 is 0, all lines are high.
- R3: A write to offset 0x8 sends bits 7:0 of the written data on `mosi_o`, most significant bit first, with exactly eight leading and eight trailing SCK transitions.
- R4: Control bit 1 (ready) is cleared by an accepted write to 0x8. It reads 1 from exactly 8·N clock edges after the edge that accepted that write, where N is the divisor of R7.
- R5: After completion, bits 7:0 at offset 0xC hold the eight bits sampled from `miso_i`, with the first sampled bit in bit 7.
- R6: Configuration register (offset 0x4) bits 13:12 select the mode. Bit 13 sets the idle SCK level. When bit 12 is 0, data is sampled on the leading edge and changes on the trailing edge. When bit 12 is 1, data changes on the leading edge and is sampled on the trailing edge. While idle, SCK follows bit 13 one cycle after it is written.
- R7: The SCK period is N core cycles, where N = max(S, 2)·2^P. S is configuration bits 3:0. P is a 3-bit value whose bit 0 is configuration bit 4 and whose bits 2:1 are configuration bits 7:6.
- R8: The event bit (bit 0 at offset 0x10) sets when a byte completes. Writing it with bit 0 = 0 clears it, but a completion on the same edge wins. The mask is bit 0 at 0x14. `irq_o` equals event AND mask.
- R9: A write to 0x8 while a byte is in flight is ignored: the current byte, its timing and its result are unchanged.
- R10: Configuration bit 5 is stored and read back, together with bits 13:12 and 7:0, but it has no effect on the exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 5 | Byte address of the register |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| miso_i | input | 1 | Serial data from the slave |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| cs_no | output | 8 | Active-low select lines |
| irq_o | output | 1 | Masked completion interrupt |

## Verification
A wrong period count or bit count shows at the ports within one byte: the interrupt rises a cycle early or late, or the slave sees a seventh or ninth clock edge. A wrong select decode or mask is visible on the very next clock. A swapped phase setting corrupts the byte the slave captures and the value read from 0xC, which is visible at the end of the byte in which it occurs. The bench compares select lines, interrupt and idle clock level against its model on every cycle. This catches timing faults to the exact cycle, not just at the end of the byte.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam int REG_IDX_W = 3;
  localparam int SPR_W     = 4;
  localparam int SPPR_W    = 3;

  typedef enum logic [REG_IDX_W-1:0] {
    RA_CTRL  = 3'd0,
    RA_CONF  = 3'd1,
    RA_TX    = 3'd2,
    RA_RX    = 3'd3,
    RA_ISTAT = 3'd4,
    RA_IMASK = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic              cpol;
    logic              cpha;
    logic [SPR_W-1:0]  spr;
    logic [SPPR_W-1:0] sppr;
  } xfer_cfg_t;
endpackage

// File: rtl/sbm_regs.sv
module sbm_regs
  import sbm_pkg::*;
#(
  parameter int NCS  = 8,
  parameter int AW   = 5,
  parameter int DW   = 32,
  parameter int BITS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic            we_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic            busy_i,
  input  logic            done_i,
  input  logic [BITS-1:0] rx_byte_i,
  output logic            start_o,
  output logic [BITS-1:0] tx_byte_o,
  output xfer_cfg_t       cfg_o,
  output logic [NCS-1:0]  cs_no,
  output logic            irq_o
);
  localparam int CS_W   = $clog2(NCS);
  localparam int CONF_W = 14;
  localparam logic [CONF_W-1:0] CONF_KEEP = 14'h30FF;

  reg_addr_e sel;
  logic wr_ctrl, wr_conf, wr_tx, wr_stat, wr_mask;
  logic            cs_en_q, cs_en_d;
  logic [CS_W-1:0] cs_idx_q, cs_idx_d;
  logic            ready_q, ready_d;
  logic [CONF_W-1:0] conf_q, conf_d;
  logic            stat_q, stat_d, mask_q, mask_d;
  logic            unused_bits;

  assign sel     = reg_addr_e'(addr_i[2 +: REG_IDX_W]);
  assign wr_ctrl = we_i && (sel == RA_CTRL);
  assign wr_conf = we_i && (sel == RA_CONF);
  assign wr_tx   = we_i && (sel == RA_TX);
  assign wr_stat = we_i && (sel == RA_ISTAT);
  assign wr_mask = we_i && (sel == RA_IMASK);
  assign unused_bits = ^{addr_i[1:0], wdata_i[DW-1:CONF_W]};

  assign start_o   = wr_tx && !busy_i;
  assign tx_byte_o = wdata_i[BITS-1:0];

  always_comb begin
    cs_en_d  = wr_ctrl ? wdata_i[0] : cs_en_q;
    cs_idx_d = wr_ctrl ? wdata_i[2 +: CS_W] : cs_idx_q;
    conf_d   = wr_conf ? (wdata_i[CONF_W-1:0] & CONF_KEEP) : conf_q;
    mask_d   = wr_mask ? wdata_i[0] : mask_q;
    ready_d  = ready_q;
    if (done_i)       ready_d = 1'b1;
    else if (start_o) ready_d = 1'b0;
    stat_d = stat_q;
    if (done_i)                       stat_d = 1'b1;
    else if (wr_stat && !wdata_i[0])  stat_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_en_q  <= 1'b0;
      cs_idx_q <= '0;
      ready_q  <= 1'b0;
      conf_q   <= '0;
      stat_q   <= 1'b0;
      mask_q   <= 1'b0;
    end else begin
      cs_en_q  <= cs_en_d;
      cs_idx_q <= cs_idx_d;
      ready_q  <= ready_d;
      conf_q   <= conf_d;
      stat_q   <= stat_d;
      mask_q   <= mask_d;
    end
  end

  assign cfg_o.cpol = conf_q[13];
  assign cfg_o.cpha = conf_q[12];
  assign cfg_o.spr  = conf_q[SPR_W-1:0];
  assign cfg_o.sppr = {conf_q[7:6], conf_q[4]};

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_no[i] = !(cs_en_q && (cs_idx_q == CS_W'(i)));
  end

  assign irq_o = stat_q & mask_q;

  always_comb begin
    rdata_o = '0;
    case (sel)
      RA_CTRL:  rdata_o[2+CS_W-1:0] = {cs_idx_q, ready_q, cs_en_q};
      RA_CONF:  rdata_o[CONF_W-1:0] = conf_q;
      RA_RX:    rdata_o[BITS-1:0]   = rx_byte_i;
      RA_ISTAT: rdata_o[0]          = stat_q;
      RA_IMASK: rdata_o[0]          = mask_q;
      default:  rdata_o = '0;
    endcase
  end

  // R2
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));
  // R8
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> mask_q);
  // R4
  ready_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (ready_q && stat_q));
endmodule

// File: rtl/sbm_prescale.sv
module sbm_prescale
  import sbm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              run_i,
  input  logic [SPR_W-1:0]  spr_i,
  input  logic [SPPR_W-1:0] sppr_i,
  output logic              lead_o,
  output logic              trail_o,
  output logic              wrap_o
);
  localparam int DIV_W = SPR_W + (1 << SPPR_W) - 1;

  logic [DIV_W-1:0] spr_eff, n_full, n_half, cnt_q, cnt_d;

  assign spr_eff = (spr_i < SPR_W'(2)) ? DIV_W'(2) : DIV_W'(spr_i);
  assign n_full  = spr_eff << sppr_i;
  assign n_half  = n_full >> 1;

  assign lead_o  = run_i && (cnt_q == '0);
  assign trail_o = run_i && (cnt_q == n_half);
  assign wrap_o  = run_i && (cnt_q == (n_full - DIV_W'(1)));

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)     cnt_d = '0;
    else if (wrap_o) cnt_d = '0;
    else if (run_i)  cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < n_full));
endmodule

// File: rtl/sbm_shift.sv
module sbm_shift #(
  parameter int BITS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [BITS-1:0] tx_byte_i,
  input  logic            cpol_i,
  input  logic            cpha_i,
  input  logic            lead_i,
  input  logic            trail_i,
  input  logic            wrap_i,
  input  logic            miso_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [BITS-1:0] rx_byte_o,
  output logic            sck_o,
  output logic            mosi_o
);
  localparam int BIT_W = $clog2(BITS);

  logic             busy_q, busy_d, sck_q, sck_d, mosi_q, mosi_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [BITS-1:0]  tx_sh_q, tx_sh_d, rx_sh_q, rx_sh_d, rx_q, rx_d, rx_nxt;
  logic             shout, samp, last_bit;

  assign shout    = cpha_i ? lead_i  : trail_i;
  assign samp     = cpha_i ? trail_i : lead_i;
  assign last_bit = (bit_q == BIT_W'(BITS - 1));
  assign done_o   = wrap_i && last_bit;
  assign rx_nxt   = samp ? {rx_sh_q[BITS-2:0], miso_i} : rx_sh_q;

  always_comb begin
    busy_d  = busy_q;
    bit_d   = bit_q;
    tx_sh_d = tx_sh_q;
    mosi_d  = mosi_q;
    rx_sh_d = rx_nxt;
    rx_d    = rx_q;
    if (start_i) begin
      busy_d  = 1'b1;
      bit_d   = '0;
      rx_sh_d = '0;
      if (cpha_i) begin
        tx_sh_d = tx_byte_i;
      end else begin
        mosi_d  = tx_byte_i[BITS-1];
        tx_sh_d = tx_byte_i << 1;
      end
    end else begin
      if (shout) begin
        mosi_d  = tx_sh_q[BITS-1];
        tx_sh_d = tx_sh_q << 1;
      end
      if (done_o) begin
        busy_d = 1'b0;
        rx_d   = rx_nxt;
      end else if (wrap_i) begin
        bit_d = bit_q + BIT_W'(1);
      end
    end
    if (!busy_q || done_o) sck_d = cpol_i;
    else if (lead_i)       sck_d = ~cpol_i;
    else if (trail_i)      sck_d = cpol_i;
    else                   sck_d = sck_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      bit_q   <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      rx_q    <= '0;
      sck_q   <= 1'b0;
      mosi_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      bit_q   <= bit_d;
      tx_sh_q <= tx_sh_d;
      rx_sh_q <= rx_sh_d;
      rx_q    <= rx_d;
      sck_q   <= sck_d;
      mosi_q  <= mosi_d;
    end
  end

  assign busy_o    = busy_q;
  assign rx_byte_o = rx_q;
  assign sck_o     = sck_q;
  assign mosi_o    = mosi_q;

  // R6
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |=> (sck_o == $past(cpol_i)));
  // R9
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import sbm_pkg::*;
#(
  parameter int NCS  = 8,
  parameter int AW   = 5,
  parameter int DW   = 32,
  parameter int BITS = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [AW-1:0]  bus_addr_i,
  input  logic           bus_we_i,
  input  logic [DW-1:0]  bus_wdata_i,
  output logic [DW-1:0]  bus_rdata_o,
  input  logic           miso_i,
  output logic           sck_o,
  output logic           mosi_o,
  output logic [NCS-1:0] cs_no,
  output logic           irq_o
);
  logic [1:0]      rst_sync_q;
  logic            rst_n;
  logic            start, busy, done, lead, trail, wrap;
  logic [BITS-1:0] tx_byte, rx_byte;
  xfer_cfg_t       cfg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  sbm_regs #(.NCS(NCS), .AW(AW), .DW(DW), .BITS(BITS)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .addr_i    (bus_addr_i),
    .we_i      (bus_we_i),
    .wdata_i   (bus_wdata_i),
    .rdata_o   (bus_rdata_o),
    .busy_i    (busy),
    .done_i    (done),
    .rx_byte_i (rx_byte),
    .start_o   (start),
    .tx_byte_o (tx_byte),
    .cfg_o     (cfg),
    .cs_no     (cs_no),
    .irq_o     (irq_o)
  );

  sbm_prescale u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .start_i (start),
    .run_i   (busy),
    .spr_i   (cfg.spr),
    .sppr_i  (cfg.sppr),
    .lead_o  (lead),
    .trail_o (trail),
    .wrap_o  (wrap)
  );

  sbm_shift #(.BITS(BITS)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .start_i   (start),
    .tx_byte_i (tx_byte),
    .cpol_i    (cfg.cpol),
    .cpha_i    (cfg.cpha),
    .lead_i    (lead),
    .trail_i   (trail),
    .wrap_i    (wrap),
    .miso_i    (miso_i),
    .busy_o    (busy),
    .done_o    (done),
    .rx_byte_o (rx_byte),
    .sck_o     (sck_o),
    .mosi_o    (mosi_o)
  );
endmodule

// File: tb/spi_byte_master_test.sv
module spi_byte_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        miso, sck, mosi, irq;
  logic [7:0]  cs_n;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  spi_byte_master uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(bus_addr), .bus_we_i(bus_we),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .miso_i(miso),
    .sck_o(sck), .mosi_o(mosi), .cs_no(cs_n), .irq_o(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  bit mon_on = 0;
  bit m_en = 0, m_ready = 0, m_stat = 0, m_mask = 0, m_busy = 0;
  bit m_cpol = 0, m_sck_exp = 0, m_sck_chk = 0;
  int m_idx = 0, m_left = 0;
  logic [31:0] m_conf = '0;

  function automatic int divisor(input logic [31:0] c);
    int s, p;
    s = int'(c[3:0]);
    if (s < 2) s = 2;
    p = int'({c[7:6], c[4]});
    return s << p;
  endfunction

  always @(posedge clk) begin
    bit was_busy, done_now;
    if (mon_on) begin
      was_busy = m_busy;
      done_now = 0;
      m_sck_exp = m_cpol;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; m_ready = 1; done_now = 1;
        end
      end
      m_sck_chk = !was_busy || done_now;
      if (bus_we) begin
        case (bus_addr)
          5'h00: begin m_en = bus_wdata[0]; m_idx = int'(bus_wdata[4:2]); end
          5'h04: begin m_conf = bus_wdata; m_cpol = bus_wdata[13]; end
          5'h08: if (!was_busy) begin
                   m_busy = 1; m_left = 8 * divisor(m_conf); m_ready = 0;
                 end
          5'h10: if (!bus_wdata[0]) m_stat = 0;
          5'h14: m_mask = bus_wdata[0];
          default: ;
        endcase
      end
      if (done_now) m_stat = 1;
    end
  end

  always @(negedge clk) begin
    logic [7:0] exp_cs;
    if (mon_on) begin
      exp_cs = m_en ? ~(8'h01 << m_idx) : 8'hFF;
      chk(cs_n == exp_cs, "R2 select lines", int'(cs_n), int'(exp_cs));
      chk(irq == (m_stat & m_mask), "R8/R4 irq timing", int'(irq), int'(m_stat & m_mask));
      if (m_sck_chk)
        chk(sck == m_sck_exp, "R6 idle sck", int'(sck), int'(m_sck_exp));
    end
  end

  // ---------------- behavioural slave ----------------
  logic [7:0] sl_tx = '0, sl_rx = '0;
  int  sl_lead = 0, sl_trail = 0;
  bit  sl_cpol = 0, sl_cpha = 0;

  always @(sck) begin
    if (sck !== sl_cpol) begin
      sl_lead++;
      if (!sl_cpha) sl_rx = {sl_rx[6:0], mosi};
    end else begin
      sl_trail++;
      if (sl_cpha) sl_rx = {sl_rx[6:0], mosi};
    end
  end

  always @* begin
    int idx;
    idx = sl_cpha ? (sl_lead - 1) : sl_trail;
    if (idx < 0) idx = 0;
    miso = (idx < 8) ? sl_tx[7 - idx] : 1'b0;
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_conf(input logic [31:0] c);
    wr(5'h04, c);
    repeat (2) @(negedge clk);
    sl_cpol = c[13]; sl_cpha = c[12];
  endtask

  task automatic begin_byte(input logic [7:0] tx, input logic [7:0] stx);
    logic [31:0] v;
    wr(5'h10, 32'h0);
    sl_tx = stx; sl_rx = '0; sl_lead = 0; sl_trail = 0;
    wr(5'h08, {24'h0, tx});
    rd(5'h00, v);
    chk(v[1] == 1'b0, "R4 ready cleared by start", int'(v[1]), 0);
  endtask

  task automatic end_byte(input logic [7:0] tx, input logic [7:0] stx);
    logic [31:0] v;
    wait (!m_busy);
    @(negedge clk);
    rd(5'h0C, v);
    chk(v[7:0] == stx, "R5 received byte", int'(v[7:0]), int'(stx));
    rd(5'h00, v);
    chk(v[1] == 1'b1, "R4 ready after byte", int'(v[1]), 1);
    chk(sl_rx == tx, "R3 MOSI byte MSB first", int'(sl_rx), int'(tx));
    chk(sl_lead == 8 && sl_trail == 8, "R3 sixteen SCK edges",
        sl_lead * 100 + sl_trail, 808);
    rd(5'h10, v);
    chk(v[0] == 1'b1, "R8 event bit set", int'(v[0]), 1);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(cs_n == 8'hFF, "R1 select lines", int'(cs_n), 'hFF);
    chk(irq == 1'b0, "R1 irq", int'(irq), 0);
    chk(sck == 1'b0, "R1 sck", int'(sck), 0);
    rd(5'h00, v);
    chk(v == 32'h0, "R1 control reads 0", int'(v), 0);
    mon_on = 1;

    wr(5'h14, 32'h1);
    wr(5'h00, 32'h0000_000D);
    @(negedge clk);
    chk(cs_n == 8'hF7, "R2 index 3 low", int'(cs_n), 'hF7);

    // R7 SPR 0 treated as 2 (N=2), mode 0
    set_conf(32'h0000_0000);
    begin_byte(8'hA5, 8'h3C); end_byte(8'hA5, 8'h3C);

    // R6 mode 3, odd divisor N=3
    set_conf(32'h0000_3003);
    begin_byte(8'h5A, 8'hC3); end_byte(8'h5A, 8'hC3);

    // R7 split SPPR field: S=3, P=5 -> N=96, mode 1
    set_conf(32'h0000_1093);
    begin_byte(8'h81, 8'h7E); end_byte(8'h81, 8'h7E);

    // R10 byte-length bit stored, no effect; mode 2, S=5, P=2
    set_conf(32'hFFFF_2065);
    rd(5'h04, v);
    chk(v == 32'h0000_2065, "R10 config readback", int'(v), 'h2065);
    begin_byte(8'hF0, 8'h0F); end_byte(8'hF0, 8'h0F);

    // R8 event clear drops irq
    wr(5'h10, 32'h0);
    rd(5'h10, v);
    chk(v[0] == 1'b0, "R8 event cleared", int'(v[0]), 0);
    chk(irq == 1'b0, "R8 irq low after clear", int'(irq), 0);

    // R9 write during a byte ignored
    set_conf(32'h0000_0004);
    begin_byte(8'h96, 8'h69);
    repeat (10) @(negedge clk);
    wr(5'h08, 32'h0000_0000);
    end_byte(8'h96, 8'h69);

    // R8 mask off keeps irq low
    wr(5'h14, 32'h0);
    @(negedge clk);
    chk(irq == 1'b0, "R8 masked irq", int'(irq), 0);

    // R2 index 7, then disable
    wr(5'h00, 32'h0000_001D);
    @(negedge clk);
    chk(cs_n == 8'h7F, "R2 index 7 low", int'(cs_n), 'h7F);
    wr(5'h00, 32'h0000_001C);
    @(negedge clk);
    chk(cs_n == 8'hFF, "R2 disabled all high", int'(cs_n), 'hFF);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule